// File: doc/BRIEF.md
# I2C Configuration Register Slave

This block is the serial front end of a small configuration store. A bus master on a two-wire I2C bus reaches a bank of byte-wide registers through it. The block samples SCL and SDA with the system clock, passes each line through a two-flop synchronizer, and removes short pulses before it looks for edges and for START and STOP conditions. It answers only to one fixed 7-bit identifier. After the identifier it takes a register address byte, and then it writes data bytes into the store or shifts register contents out to the master.

The register store sits beside the block and is reached through an address, a write-data byte, a one-cycle write strobe and a read-data byte. The store returns read data one clock after the address. The store also tells the slave two things. The first is whether writes are aimed at non-volatile storage. The second is whether it is busy with a power-up recall or a self-timed non-volatile write. While busy is high, the slave ignores the bus completely, START conditions included. When a STOP closes a write and the store is in non-volatile mode, the slave sends a launch pulse that starts the store's write cycle. When a STOP closes a read, or a write in volatile mode, the slave simply returns to standby.

Top module: `i2c_cfg_slave`

## Requirements
- R1: During reset and on the first cycle after it, `sda_oe`, `reg_we` and `nv_launch` are all 0.
- R2: A first byte whose seven upper bits equal 0101000b is acknowledged by pulling SDA low during the ninth clock, and its LSB selects the direction (0 write, 1 read). Any other identifier gets no acknowledge, and the slave also ignores the bytes that follow until the next START.
- R3: A write is START, identifier with LSB 0, address byte, data byte, STOP. The slave acknowledges the address byte and the data byte. Each data byte produces a one-cycle `reg_we` pulse that carries the received address and data.
- R4: A read is START, identifier with LSB 0, address byte, repeated START, identifier with LSB 1. Register bytes are then shifted out MSB first, and the address advances by one after every byte the master acknowledges.
- R5: If the master does not acknowledge a read byte (SDA high in the ninth clock), the read ends and SDA stays released until the next START.
- R6: The slave starts pulling SDA low only while the filtered SCL is low, so SDA never changes from the slave's side during an SCL high phase.
- R7: A pulse on SCL or SDA that lasts fewer than FILT_CYC clocks (7 clocks, 56 ns at 125 MHz, which covers the 50 ns rejection limit) is ignored. It adds no bit and produces no START or STOP.
- R8: A STOP that follows at least one written data byte pulses `nv_launch` for one cycle when `nv_mode` is 1. A STOP after a read, or after a write with `nv_mode` at 0, gives no pulse.
- R9: While `store_busy` is 1 (power-up recall or a non-volatile write cycle), the slave keeps SDA released, never strobes `reg_we` and ignores START conditions. After busy drops, it responds only once a fresh START arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL line from the pad |
| sda_i | input | 1 | Raw SDA line from the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |
| store_busy | input | 1 | Store is recalling at power-up or running a non-volatile write |
| nv_mode | input | 1 | Writes are aimed at non-volatile storage |
| reg_addr | output | ADDR_W | Register address presented to the store |
| reg_wdata | output | 8 | Byte to be written |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Store contents at `reg_addr`, one clock later |
| nv_launch | output | 1 | One-cycle request that starts the non-volatile write cycle |

## Verification
The embedded properties check the following on every cycle: the write strobe and the launch pulse each last exactly one cycle, a launch only ever happens with non-volatile mode set, SDA is pulled low only while the filtered SCL is low, and the pad stays released and the strobe stays quiet in the cycle after busy is seen. Other behaviour can only be shown by the directed bus scenarios. These cover identifier matching and mismatch, address auto-increment across a multi-byte read, NACK termination, pulse rejection in the middle of a byte, and deafness to a START issued during busy that stays in force after busy falls mid-byte. Each of these needs whole byte sequences driven from outside the block.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  // Transfer phase of the slave; the order carries no meaning
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_ADDR,
    PH_WR,
    PH_RD
  } phase_t;
endpackage

// File: rtl/i2c_line_filter.sv
// Two-flop synchronizer plus a persistence filter: the output takes a new
// level only once the synchronized input has held it for FILT_CYC clocks.
module i2c_line_filter #(
  parameter int FILT_CYC = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      dout <= 1'b1;
      cnt  <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      if (s2 == dout) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_CYC - 1)) begin
        dout <= s2;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
// Edge and bus-condition detection on the filtered lines.
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign ev_start = scl_f & scl_q & sda_q & ~sda_f;
  assign ev_stop  = scl_f & scl_q & ~sda_q & sda_f;
  assign ev_rise  = scl_f & ~scl_q;
  assign ev_fall  = ~scl_f & scl_q;
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ID   = 7'b0101000,
  parameter int         FILT_CYC = 7,
  parameter int         ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              store_busy,
  input  logic              nv_mode,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              reg_we,
  input  logic [7:0]        reg_rdata,
  output logic              nv_launch
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_l, filt_l;
  logic scl_f, sda_f;
  logic ev_start, ev_stop, ev_rise, ev_fall;

  assign raw_l = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2c_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw_l[g]),
      .dout(filt_l[g])
    );
  end

  assign scl_f = filt_l[1];
  assign sda_f = filt_l[0];

  i2c_bus_events u_ev (
    .clk     (clk),
    .rst     (rst),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .ev_start(ev_start),
    .ev_stop (ev_stop),
    .ev_rise (ev_rise),
    .ev_fall (ev_fall)
  );

  phase_t            phase, nxt_ph;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg, txsh;
  logic              ack_pend, wrote;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        nb;

  assign nb       = {shreg[6:0], sda_f};
  assign reg_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      nxt_ph    <= PH_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txsh      <= '0;
      ack_pend  <= 1'b0;
      wrote     <= 1'b0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
      nv_launch <= 1'b0;
    end else begin
      reg_we    <= 1'b0;
      nv_launch <= 1'b0;
      if (store_busy) begin
        // deaf while the store recalls or programs
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
        wrote  <= 1'b0;
        bitcnt <= '0;
      end else if (ev_start) begin
        phase  <= PH_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        wrote  <= 1'b0;
      end else if (ev_stop) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
        wrote  <= 1'b0;
        if (wrote && nv_mode) nv_launch <= 1'b1;
      end else if (phase != PH_IDLE) begin
        if (ev_rise) begin
          if (bitcnt < 4'd8) begin
            shreg  <= nb;
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == 4'd7) begin
              case (phase)
                PH_DEV: begin
                  ack_pend <= (nb[7:1] == DEV_ID);
                  if (nb[7:1] != DEV_ID) nxt_ph <= PH_IDLE;
                  else                   nxt_ph <= nb[0] ? PH_RD : PH_ADDR;
                end
                PH_ADDR: begin
                  ptr      <= nb[ADDR_W-1:0];
                  ack_pend <= 1'b1;
                  nxt_ph   <= PH_WR;
                end
                PH_WR: begin
                  reg_we    <= 1'b1;
                  reg_wdata <= nb;
                  wrote     <= 1'b1;
                  ack_pend  <= 1'b1;
                  nxt_ph    <= PH_WR;
                end
                default: begin
                  ack_pend <= 1'b0;
                  nxt_ph   <= PH_RD;
                end
              endcase
            end
          end else begin
            // rising edge of the acknowledge clock
            bitcnt <= 4'd9;
            if (phase == PH_WR) ptr <= ptr + 1'b1;
            if (phase == PH_RD) begin
              if (sda_f) nxt_ph <= PH_IDLE;
              else       ptr    <= ptr + 1'b1;
            end
          end
        end else if (ev_fall) begin
          if (bitcnt == 4'd8) begin
            sda_oe <= ack_pend;
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            phase  <= nxt_ph;
            if (nxt_ph == PH_RD) begin
              sda_oe <= ~reg_rdata[7];
              txsh   <= {reg_rdata[6:0], 1'b0};
            end else begin
              sda_oe <= 1'b0;
            end
          end else if (phase == PH_RD) begin
            sda_oe <= ~txsh[7];
            txsh   <= {txsh[6:0], 1'b0};
          end
        end
      end
    end
  end

  // R3
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R8
  launch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    nv_launch |=> !nv_launch);

  // R8
  launch_mode_chk: assert property (@(posedge clk) disable iff (rst)
    nv_launch |-> $past(nv_mode));

  // R6
  drive_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_f);

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(store_busy) |-> (!sda_oe && !reg_we));
endmodule

// File: tb/i2c_cfg_slave_tb.sv
module i2c_cfg_slave_tb;
  localparam int Q = 200;
  localparam int H = 400;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe, reg_we, nv_launch;
  logic       store_busy = 1'b1, nv_mode = 1'b0;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       sda_bus;
  logic [7:0] mem [256];

  int nchk = 0, nfail = 0;
  int we_cnt = 0, nv_cnt = 0;
  logic [7:0] last_a = '0, last_d = '0;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_cfg_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .store_busy(store_busy), .nv_mode(nv_mode), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .nv_launch(nv_launch)
  );

  // register store model: registered read, one-clock latency
  always @(posedge clk) begin
    if (reg_we) mem[reg_addr] <= reg_wdata;
    reg_rdata <= mem[reg_addr];
  end

  always @(negedge clk) begin
    if (!rst && reg_we) begin
      we_cnt++; last_a = reg_addr; last_d = reg_wdata;
    end
    if (!rst && nv_launch) nv_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #H;
  endtask

  // glitch: 1 = short SCL pulse while low, 2 = short SDA low pulse while high
  task automatic send_bit(input logic b, input int glitch);
    sda_m = b; #Q;
    if (glitch == 1) begin scl_m = 1'b1; #32; scl_m = 1'b0; #(Q - 32); end
    scl_m = 1'b1;
    if (glitch == 2 && b) begin #(Q - 40); sda_m = 1'b0; #40; sda_m = 1'b1; #Q; end
    else #H;
    scl_m = 1'b0; #Q;
  endtask

  task automatic send_byte(input logic [7:0] v, input int glitch, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i], (i == 4) ? glitch : ((i == 2 && glitch == 2) ? 2 : 0));
    sda_m = 1'b1; #Q; scl_m = 1'b1; #(H/2); ack = ~sda_bus; #(H/2); scl_m = 1'b0; #Q;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v, output logic steady);
    logic s0, s1;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; #Q; scl_m = 1'b1; #40; s0 = sda_bus; #(H - 80); s1 = sda_bus; #40;
      scl_m = 1'b0; #Q;
      v[i] = s0;
      if (s0 != s1) steady = 1'b0;
    end
    sda_m = ~mack; #Q; scl_m = 1'b1; #H; scl_m = 1'b0; #Q; sda_m = 1'b1;
  endtask

  task automatic write_txn(input logic [7:0] a, input logic [7:0] d, output logic [2:0] acks);
    logic k;
    bus_start();
    send_byte(8'h50, 0, k); acks[2] = k;
    send_byte(a, 0, k);     acks[1] = k;
    send_byte(d, 0, k);     acks[0] = k;
    bus_stop();
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    chk(reg_we == 1'b0, "R1 reg_we after reset", reg_we, 0);
    chk(nv_launch == 1'b0, "R1 nv_launch after reset", nv_launch, 0);
  endtask

  task automatic t_powerup_busy();
    logic k;
    bus_start(); send_byte(8'h50, 0, k); bus_stop();
    chk(k == 1'b0, "R9 no ack during power-up recall", k, 0);
    store_busy = 1'b0; #H;
  endtask

  task automatic t_volatile_write();
    logic [2:0] acks; int w0, n0;
    w0 = we_cnt; n0 = nv_cnt; nv_mode = 1'b0;
    write_txn(8'h05, 8'hA7, acks);
    chk(acks == 3'b111, "R2 R3 acks on id/addr/data", acks, 7);
    chk(we_cnt == w0 + 1, "R3 one write strobe", we_cnt - w0, 1);
    chk(last_a == 8'h05 && last_d == 8'hA7, "R3 strobe addr/data", {last_a, last_d}, 16'h05A7);
    chk(nv_cnt == n0, "R8 no launch in volatile mode", nv_cnt - n0, 0);
  endtask

  task automatic t_nv_write_then_busy();
    logic [2:0] acks; logic k; int w0, n0;
    n0 = nv_cnt; nv_mode = 1'b1;
    write_txn(8'h06, 8'h3C, acks);
    chk(acks == 3'b111, "R3 acks nv write", acks, 7);
    chk(nv_cnt == n0 + 1, "R8 launch after nv write", nv_cnt - n0, 1);
    store_busy = 1'b1; w0 = we_cnt;
    write_txn(8'h07, 8'h55, acks);
    chk(acks == 3'b000, "R9 no ack while busy", acks, 0);
    // START during busy, busy drops mid-byte
    bus_start();
    send_bit(1'b0, 0); send_bit(1'b1, 0); send_bit(1'b0, 0);
    store_busy = 1'b0;
    for (int i = 4; i >= 0; i--) send_bit(1'b0, 0);
    sda_m = 1'b1; #Q; scl_m = 1'b1; #(H/2); k = ~sda_bus; #(H/2); scl_m = 1'b0; #Q;
    send_byte(8'h07, 0, k);
    chk(k == 1'b0, "R9 START under busy stays ignored", k, 0);
    bus_stop();
    chk(we_cnt == w0, "R9 no strobe while deaf", we_cnt - w0, 0);
    nv_mode = 1'b0;
    write_txn(8'h07, 8'h55, acks);
    chk(acks == 3'b111 && last_d == 8'h55, "R9 responds after fresh START", {acks, last_d}, 11'h755);
  endtask

  task automatic t_read();
    logic k, st; logic [7:0] v; int n0;
    n0 = nv_cnt; nv_mode = 1'b1;
    bus_start(); send_byte(8'h50, 0, k); send_byte(8'h05, 0, k);
    bus_start(); send_byte(8'h51, 0, k);
    chk(k == 1'b1, "R4 ack on read identifier", k, 1);
    recv_byte(1'b1, v, st);
    chk(v == 8'hA7, "R4 first read byte", v, 8'hA7);
    chk(st == 1'b1, "R6 SDA steady while SCL high", st, 1);
    recv_byte(1'b0, v, st);
    chk(v == 8'h3C, "R4 address increments", v, 8'h3C);
    // master NACK ended the read: further clocks see SDA released
    recv_byte(1'b0, v, st);
    chk(v == 8'hFF, "R5 SDA released after NACK", v, 8'hFF);
    bus_stop();
    chk(nv_cnt == n0, "R8 no launch after read", nv_cnt - n0, 0);
    nv_mode = 1'b0;
  endtask

  task automatic t_bad_id();
    logic k1, k2; int w0;
    w0 = we_cnt;
    bus_start(); send_byte(8'h52, 0, k1); send_byte(8'h50, 0, k2); send_byte(8'h11, 0, k2);
    bus_stop();
    chk(k1 == 1'b0, "R2 no ack on wrong identifier", k1, 0);
    chk(k2 == 1'b0 && we_cnt == w0, "R2 silent until next START", k2, 0);
  endtask

  task automatic t_glitch();
    logic k1, k2, k3;
    bus_start(); send_byte(8'h50, 0, k1); send_byte(8'h09, 1, k2); send_byte(8'hB5, 2, k3);
    bus_stop();
    chk(k1 && k2 && k3, "R7 acks with glitches", {k1, k2, k3}, 7);
    chk(last_a == 8'h09 && last_d == 8'hB5, "R7 glitches rejected", {last_a, last_d}, 16'h09B5);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    #3;
    #80 rst = 1'b0;
    #8;
    t_reset();
    t_powerup_busy();
    t_volatile_write();
    t_nv_write_then_busy();
    t_read();
    t_bad_id();
    t_glitch();
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end
endmodule